// File: doc/BRIEF.md
# Serial Character Sync Detector

This block sits behind a serial receiver and finds character boundaries in a raw bit stream. It is in hunt while it has no alignment. In hunt it compares the most recent bits with a programmed sync pattern on every valid bit. The pattern length is selectable: a 4-bit nibble, one 8-bit character, or two 8-bit characters received back to back. A fourth setting ignores the pattern and takes alignment from an external sync pulse.

Once aligned, the block is locked. It packs every following group of eight bits into a character and delivers it with a one-cycle strobe. Fill characters equal to the sync pattern are dropped, so only payload reaches the consumer. A bit-order option selects whether the first bit on the line is the most or the least significant bit of a character. A hunt command from the controller drops alignment at any time.

Top module: `char_sync_detector`

## Requirements
- R1: After reset, `locked_o`, `char_vld_o` and `sync_hit_o` are all low.
- R2: With `len_sel_i` = 2 (two-character mode), the block locks when the last 16 valid bits on the line equal `syn_a_i` followed by `syn_b_i`, each character in the line order set by `rev_i`.
- R3: With `len_sel_i` = 1 (one-character mode), the block locks when the last 8 valid bits equal `syn_a_i` in line order.
- R4: With `len_sel_i` = 0 (nibble mode), the block locks when the last 4 valid bits equal `syn_a_i[3:0]` in line order.
- R5: With `len_sel_i` = 3 (external mode), pattern matches are ignored. The block locks on a valid bit that arrives with `ext_sync_i` high, and that bit is the last bit of the sync.
- R6: `sync_hit_o` pulses for exactly one cycle, in the cycle after the bit that completes the sync while in hunt. `locked_o` rises in the same cycle, and neither changes again while locked.
- R7: With `rev_i` = 0, the first bit after the sync and every eighth bit after it begin a character and become its bit 7. `char_vld_o` pulses in the cycle after the eighth bit of a character.
- R8: With `rev_i` = 1, the first bit of each character becomes bit 0. The sync pattern is also compared least significant bit first.
- R9: Once locked, a completed character is not delivered if it equals `syn_a_i`. In two-character mode, one equal to `syn_b_i` is not delivered either. In nibble mode, one equal to `{syn_a_i[3:0], syn_a_i[3:0]}` is not delivered either.
- R10: `hunt_i` returns the block to hunt in the next cycle and discards a partial character. This includes a character whose eighth bit arrives in the same cycle as `hunt_i`. A sync completed in that cycle does not lock.
- R11: A cycle with `bit_vld_i` low and `hunt_i` low leaves the lock state and the bit count unchanged, and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Received serial bit |
| bit_vld_i | input | 1 | `bit_i` carries a new bit this cycle |
| syn_a_i | input | 8 | First sync character; its low nibble is the nibble pattern |
| syn_b_i | input | 8 | Second sync character for the two-character mode |
| len_sel_i | input | 2 | 0 nibble, 1 one character, 2 two characters, 3 external |
| rev_i | input | 1 | 1: least significant bit first on the line |
| hunt_i | input | 1 | Drop alignment and return to hunt |
| ext_sync_i | input | 1 | External alignment pulse, used in mode 3 |
| char_o | output | 8 | Assembled character |
| char_vld_o | output | 1 | One-cycle strobe for `char_o` |
| locked_o | output | 1 | Character alignment is held |
| sync_hit_o | output | 1 | One-cycle pulse when alignment is acquired |

## Verification
The hunt command can arrive in the same cycle as the eighth bit of a character, and the bench forces this. Its own model tracks the bit count, and it raises `hunt_i` exactly when that count reaches the last bit of a character. The check is that no strobe follows and that `locked_o` falls. A second collision is a pattern match while `hunt_i` is high. This arises naturally in the sweeps because the bit history is kept across a hunt, and the check is that no lock is taken.

// File: rtl/csd_pkg.sv
package csd_pkg;
    typedef enum logic [1:0] {
        SL_NIB  = 2'd0,
        SL_MONO = 2'd1,
        SL_BI   = 2'd2,
        SL_EXT  = 2'd3
    } slen_e;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } fstate_e;
endpackage

// File: rtl/csd_history.sv
module csd_history #(
    parameter int HIST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              bit_vld_i,
    output logic [HIST_W-1:0] hist_nx_o
);
    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_s;

    hist_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_vld_i) begin
            st_d.bits = {st_q.bits[HIST_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // newest bit sits at index 0, including the bit arriving this cycle
    assign hist_nx_o = st_d.bits;
endmodule

// File: rtl/csd_matcher.sv
module csd_matcher #(
    parameter int CHAR_W = 8
) (
    input  logic [2*CHAR_W-1:0] hist_i,
    input  logic [CHAR_W-1:0]   syn_a_i,
    input  logic [CHAR_W-1:0]   syn_b_i,
    input  csd_pkg::slen_e      mode_i,
    input  logic                rev_i,
    output logic                match_o
);
    import csd_pkg::*;

    localparam int NIB_W = CHAR_W / 2;

    logic [CHAR_W-1:0] a_flip, b_flip, line_a, line_b;
    logic [NIB_W-1:0]  n_flip, line_n;

    for (genvar i = 0; i < CHAR_W; i++) begin : g_flip_char
        assign a_flip[i] = syn_a_i[CHAR_W-1-i];
        assign b_flip[i] = syn_b_i[CHAR_W-1-i];
    end

    for (genvar j = 0; j < NIB_W; j++) begin : g_flip_nib
        assign n_flip[j] = syn_a_i[NIB_W-1-j];
    end

    always_comb begin
        line_a = rev_i ? a_flip : syn_a_i;
        line_b = rev_i ? b_flip : syn_b_i;
        line_n = rev_i ? n_flip : syn_a_i[NIB_W-1:0];
        unique case (mode_i)
            SL_NIB:  match_o = (hist_i[NIB_W-1:0] == line_n);
            SL_MONO: match_o = (hist_i[CHAR_W-1:0] == line_a);
            SL_BI:   match_o = (hist_i == {line_a, line_b});
            default: match_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/csd_strip.sv
module csd_strip #(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] char_i,
    input  logic [CHAR_W-1:0] syn_a_i,
    input  logic [CHAR_W-1:0] syn_b_i,
    input  csd_pkg::slen_e    mode_i,
    output logic              fill_o
);
    import csd_pkg::*;

    localparam int NIB_W = CHAR_W / 2;

    logic hit_a, hit_b, hit_n;

    always_comb begin
        hit_a  = (char_i == syn_a_i);
        hit_b  = (mode_i == SL_BI) && (char_i == syn_b_i);
        hit_n  = (mode_i == SL_NIB) &&
                 (char_i == {syn_a_i[NIB_W-1:0], syn_a_i[NIB_W-1:0]});
        fill_o = hit_a | hit_b | hit_n;
    end
endmodule

// File: rtl/csd_framer.sv
module csd_framer #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              bit_vld_i,
    input  logic              hunt_i,
    input  logic              ext_sync_i,
    input  logic              rev_i,
    input  csd_pkg::slen_e    mode_i,
    input  logic              match_i,
    input  logic              fill_i,
    output logic [CHAR_W-1:0] asm_nx_o,
    output logic [CHAR_W-1:0] char_o,
    output logic              char_vld_o,
    output logic              locked_o,
    output logic              sync_hit_o
);
    import csd_pkg::*;

    localparam int CNT_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        fstate_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [CHAR_W-1:0] acc;
        logic [CHAR_W-1:0] chr;
        logic              vld;
        logic              hit;
    } fr_s;

    fr_s st_d, st_q;
    logic [CHAR_W-1:0] acc_nx;
    logic              sync_ev;

    always_comb begin
        acc_nx  = rev_i ? {bit_i, st_q.acc[CHAR_W-1:1]}
                        : {st_q.acc[CHAR_W-2:0], bit_i};
        sync_ev = (mode_i == SL_EXT) ? ext_sync_i : match_i;

        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.hit = 1'b0;

        if (hunt_i) begin
            st_d.st  = ST_HUNT;
            st_d.cnt = '0;
            st_d.acc = '0;
        end else if (bit_vld_i) begin
            unique case (st_q.st)
                ST_HUNT: begin
                    if (sync_ev) begin
                        st_d.st  = ST_LOCK;
                        st_d.cnt = '0;
                        st_d.acc = '0;
                        st_d.hit = 1'b1;
                    end
                end
                default: begin
                    st_d.acc = acc_nx;
                    if (st_q.cnt == LAST) begin
                        st_d.cnt = '0;
                        if (!fill_i) begin
                            st_d.chr = acc_nx;
                            st_d.vld = 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_HUNT, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign asm_nx_o   = acc_nx;
    assign char_o     = st_q.chr;
    assign char_vld_o = st_q.vld;
    assign locked_o   = (st_q.st == ST_LOCK);
    assign sync_hit_o = st_q.hit;
endmodule

// File: rtl/char_sync_detector.sv
module char_sync_detector #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              bit_vld_i,
    input  logic [CHAR_W-1:0] syn_a_i,
    input  logic [CHAR_W-1:0] syn_b_i,
    input  logic [1:0]        len_sel_i,
    input  logic              rev_i,
    input  logic              hunt_i,
    input  logic              ext_sync_i,
    output logic [CHAR_W-1:0] char_o,
    output logic              char_vld_o,
    output logic              locked_o,
    output logic              sync_hit_o
);
    import csd_pkg::*;

    localparam int HIST_W = 2 * CHAR_W;

    slen_e             mode;
    logic [HIST_W-1:0] hist_nx;
    logic [CHAR_W-1:0] asm_nx;
    logic              match, fill;

    assign mode = slen_e'(len_sel_i);

    csd_history #(.HIST_W(HIST_W)) hist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_i     (bit_i),
        .bit_vld_i (bit_vld_i),
        .hist_nx_o (hist_nx)
    );

    csd_matcher #(.CHAR_W(CHAR_W)) match_i (
        .hist_i  (hist_nx),
        .syn_a_i (syn_a_i),
        .syn_b_i (syn_b_i),
        .mode_i  (mode),
        .rev_i   (rev_i),
        .match_o (match)
    );

    csd_strip #(.CHAR_W(CHAR_W)) strip_i (
        .char_i  (asm_nx),
        .syn_a_i (syn_a_i),
        .syn_b_i (syn_b_i),
        .mode_i  (mode),
        .fill_o  (fill)
    );

    csd_framer #(.CHAR_W(CHAR_W)) framer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_i      (bit_i),
        .bit_vld_i  (bit_vld_i),
        .hunt_i     (hunt_i),
        .ext_sync_i (ext_sync_i),
        .rev_i      (rev_i),
        .mode_i     (mode),
        .match_i    (match),
        .fill_i     (fill),
        .asm_nx_o   (asm_nx),
        .char_o     (char_o),
        .char_vld_o (char_vld_o),
        .locked_o   (locked_o),
        .sync_hit_o (sync_hit_o)
    );
endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_vld_i,
    input logic              hunt_i,
    input logic [CHAR_W-1:0] syn_a_i,
    input logic [CHAR_W-1:0] char_o,
    input logic              char_vld_o,
    input logic              locked_o,
    input logic              sync_hit_o
);
    // R6: a hit pulse marks the transition from hunt into lock
    a_r6_hit_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit_o |-> (locked_o && !$past(locked_o)));

    // R6: the pulse lasts a single cycle
    a_r6_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit_o |=> !sync_hit_o);

    // R7: a character can only come out of a lock held over the previous cycle
    a_r7_vld_locked: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld_o |-> (locked_o && $past(locked_o)));

    // R9: a delivered character never equals the first sync character
    a_r9_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld_o |-> (char_o != $past(syn_a_i)));

    // R10: hunt clears lock and suppresses both strobes next cycle
    a_r10_hunt_drop: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_i |=> (!locked_o && !char_vld_o && !sync_hit_o));

    // R11: an empty cycle holds state and emits nothing
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld_i && !hunt_i) |=> (!char_vld_o && !sync_hit_o && $stable(locked_o)));
endmodule

bind char_sync_detector csd_checker #(.CHAR_W(CHAR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld_i  (bit_vld_i),
    .hunt_i     (hunt_i),
    .syn_a_i    (syn_a_i),
    .char_o     (char_o),
    .char_vld_o (char_vld_o),
    .locked_o   (locked_o),
    .sync_hit_o (sync_hit_o)
);

// File: tb/char_sync_detector_tb_top.sv
module char_sync_detector_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_i = 1'b0, bit_vld_i = 1'b0, rev_i = 1'b0;
    logic       hunt_i = 1'b0, ext_sync_i = 1'b0;
    logic [7:0] syn_a_i = 8'h00, syn_b_i = 8'h00;
    logic [1:0] len_sel_i = 2'd0;
    logic [7:0] char_o;
    logic       char_vld_o, locked_o, sync_hit_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    char_sync_detector dut_i (
        .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
        .syn_a_i(syn_a_i), .syn_b_i(syn_b_i), .len_sel_i(len_sel_i),
        .rev_i(rev_i), .hunt_i(hunt_i), .ext_sync_i(ext_sync_i),
        .char_o(char_o), .char_vld_o(char_vld_o), .locked_o(locked_o),
        .sync_hit_o(sync_hit_o)
    );

    // bench model state
    logic [15:0] m_hist = '0;
    bit          m_lock = 0;
    int          m_cnt  = 0;
    logic [7:0]  m_byte = '0;
    bit          e_hit = 0, e_vld = 0;
    logic [7:0]  e_char = '0;
    logic [15:0] lf = 16'hACE1;
    bit          hac_arm = 0;

    function automatic logic [7:0] flip8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic bit rnd();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    function automatic bit model_match();
        logic [7:0] a, b;
        logic [3:0] n;
        a = rev_i ? flip8(syn_a_i) : syn_a_i;
        b = rev_i ? flip8(syn_b_i) : syn_b_i;
        n = rev_i ? {syn_a_i[0], syn_a_i[1], syn_a_i[2], syn_a_i[3]} : syn_a_i[3:0];
        case (len_sel_i)
            2'd0: return m_hist[3:0] == n;
            2'd1: return m_hist[7:0] == a;
            2'd2: return m_hist == {a, b};
            default: return 1'b0;
        endcase
    endfunction

    function automatic string mode_tag();
        case (len_sel_i)
            2'd0: return "R4";
            2'd1: return "R3";
            2'd2: return "R2";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string lock_tag);
        chk(lock_tag, "locked", int'(locked_o), int'(m_lock));
        chk("R6", "sync_hit", int'(sync_hit_o), int'(e_hit));
        chk("R9", "char_vld", int'(char_vld_o), int'(e_vld));
        if (e_vld && char_vld_o)
            chk(rev_i ? "R8" : "R7", "char", int'(char_o), int'(e_char));
    endtask

    task automatic send_bit(input logic b, input logic e, input logic h0);
        logic h;
        h = h0;
        if (hac_arm && m_lock && m_cnt == 7) begin
            h = 1'b1;
            hac_arm = 0;
        end
        @(negedge clk);
        bit_vld_i = 1'b1; bit_i = b; ext_sync_i = e; hunt_i = h;
        e_hit = 0; e_vld = 0;
        m_hist = {m_hist[14:0], b};
        if (h) begin
            m_lock = 0; m_cnt = 0;
        end else if (!m_lock) begin
            if ((len_sel_i == 2'd3) ? e : model_match()) begin
                m_lock = 1; m_cnt = 0; e_hit = 1;
            end
        end else begin
            if (rev_i) m_byte[m_cnt] = b;
            else m_byte[7-m_cnt] = b;
            m_cnt++;
            if (m_cnt == 8) begin
                m_cnt = 0;
                if (!(m_byte == syn_a_i ||
                      (len_sel_i == 2'd2 && m_byte == syn_b_i) ||
                      (len_sel_i == 2'd0 && m_byte == {syn_a_i[3:0], syn_a_i[3:0]}))) begin
                    e_vld = 1; e_char = m_byte;
                end
            end
        end
        @(posedge clk); #2;
        compare(h ? "R10" : mode_tag());
        if (rnd()) idle(1'b0);
    endtask

    task automatic idle(input logic h);
        @(negedge clk);
        bit_vld_i = 1'b0; ext_sync_i = 1'b0; hunt_i = h; bit_i = rnd();
        e_hit = 0; e_vld = 0;
        if (h) begin m_lock = 0; m_cnt = 0; end
        @(posedge clk); #2;
        compare(h ? "R10" : "R11");
    endtask

    task automatic send_char(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(rev_i ? v[i] : v[7-i], 1'b0, 1'b0);
    endtask

    task automatic send_sync();
        if (len_sel_i == 2'd0) begin
            for (int i = 0; i < 4; i++) send_bit(rev_i ? syn_a_i[i] : syn_a_i[3-i], 1'b0, 1'b0);
        end else if (len_sel_i == 2'd3) begin
            for (int i = 0; i < 5; i++) send_bit(rnd(), 1'b0, 1'b0);
            send_bit(rnd(), 1'b1, 1'b0);
        end else begin
            send_char(syn_a_i);
            if (len_sel_i == 2'd2) send_char(syn_b_i);
        end
    endtask

    task automatic run_cfg(input logic [7:0] a, input logic [7:0] b, input int md, input bit rv);
        idle(1'b1);
        syn_a_i = a; syn_b_i = b; len_sel_i = 2'(md); rev_i = rv;
        idle(1'b0);
        for (int i = 0; i < 12; i++) send_bit(rnd(), 1'b0, 1'b0);
        send_sync();
        send_char(a);
        if (md == 2) send_char(b);
        if (md == 0) send_char({a[3:0], a[3:0]});
        for (int k = 0; k < 2; k++) send_char({rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd()});
        for (int i = 0; i < 3; i++) send_bit(rnd(), 1'b0, 1'b0);
        send_bit(rnd(), 1'b0, 1'b1);   // R10: hunt with a partial character
        send_sync();
        send_char(8'h5A ^ a);
        hac_arm = 1;                    // R10: hunt on the eighth bit of a character
        for (int k = 0; k < 3; k++) send_char({rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd()});
        hac_arm = 0;
        idle(1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1", "locked", int'(locked_o), 0);
        chk("R1", "char_vld", int'(char_vld_o), 0);
        chk("R1", "sync_hit", int'(sync_hit_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 3; p++) begin
            logic [7:0] a, b;
            a = (p == 0) ? 8'h32 : (p == 1) ? 8'h7E : 8'hA5;
            b = (p == 0) ? 8'h16 : (p == 1) ? 8'h81 : 8'h3C;
            for (int md = 0; md < 4; md++)
                for (int rv = 0; rv < 2; rv++)
                    run_cfg(a, b, md, rv[0]);
        end
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule